// File: doc/BRIEF.md
# Password-Gated Block Write Protection Unit

This unit sits in front of a flash program/erase engine and decides, for every request aimed at one of 39 erase blocks (8 parameter blocks and 31 main blocks), whether that block may be modified. It combines three protections: a write-protect pin guarding two lockable parameter blocks plus every main block, a reset pin that shuts out all modification and re-arms the software lock, and a software lock keyed by a 64-bit one-time-programmable code. Which blocks each protection covers depends on whether the parameter blocks sit at the bottom or at the top of the address space, chosen by the `BOOT` parameter.

Requests arrive on a valid/ready channel. `req_ready` is held high, so the unit never applies back-pressure: every cycle with `req_valid` high is one accepted request, and its verdict appears on `rsp_valid`/`rsp_grant` exactly one cycle later. Unlock attempts and code-program requests are single-cycle strobes. A denied request raises a sticky error flag; the software lock state is reported on one status bit.

Top module: `wrprot_gate`

## Requirements
- R1: After `rst_n` deasserts, `soft_locked` reads 1 (1 = locked, 0 = unlocked), `rsp_valid`, `rsp_grant` and `prot_err` read 0, and the stored code is all ones.
- R2: An unlock strobe whose 64-bit value equals the stored code clears `soft_locked` on the next cycle; a non-matching value leaves the lock state unchanged.
- R3: A program strobe replaces the code with (code AND `prg_data`), so bits only go from 1 to 0; it takes effect only while unlocked and is ignored while locked.
- R4: Once the stored code is all zeros, program strobes no longer change it (unlocking with the all-zero value still works).
- R5: The software lock covers blocks 0, 1 and 15 to 38 with bottom boot, and blocks 0 to 23, 37 and 38 with top boot; a covered block is denied while locked.
- R6: While `wp_n` is 0, blocks 0, 1 and 8 to 38 (bottom boot) or blocks 0 to 30, 37 and 38 (top boot) are denied; the remaining parameter blocks are unaffected.
- R7: While `rp_n` is 0, every request is denied, unlock and program strobes are ignored, and `soft_locked` is forced to 1.
- R8: The pins never change the lock state: with `wp_n` and `rp_n` both 1, a software-locked block is still denied; a request is granted only when no active protection covers it.
- R9: For the first `PWRUP_CYC` (default 4) clock edges after `rst_n` deasserts, all requests are denied and unlock and program strobes are ignored.
- R10: With `SOFT_LOCK_EN` = 0, `soft_locked` stays 0, program strobes are ignored and only the pin and power-up protections apply.
- R11: `req_ready` is always 1; each request gets `rsp_valid` = 1 on the following cycle; block numbers 39 and above are always denied.
- R12: `prot_err` sets on the cycle after any denied request and stays set until `err_clr` is strobed; a denial in the same cycle as `err_clr` keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| rp_n | input | 1 | Reset pin, active low, sampled on the clock |
| wp_n | input | 1 | Write-protect pin, active low |
| req_valid | input | 1 | Program/erase request present |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_blk | input | BLK_W (6) | Target block number |
| rsp_valid | output | 1 | Verdict present, one cycle after the request |
| rsp_grant | output | 1 | 1 = modification allowed, 0 = denied |
| unl_valid | input | 1 | Unlock strobe |
| unl_code | input | CODE_W (64) | Value offered for unlock |
| prg_valid | input | 1 | Code-program strobe |
| prg_data | input | CODE_W (64) | Bit mask ANDed into the code |
| err_clr | input | 1 | Clears the protection error flag |
| prot_err | output | 1 | Sticky flag: a request was denied |
| soft_locked | output | 1 | Software lock status, 1 = locked |

## Verification
A wrong lock state shows up at once on `soft_locked` and, on the next request to a covered block, as a flipped `rsp_grant` one cycle later. A corrupted stored code is invisible until an unlock attempt: it appears as a lock that fails to open (or opens on the wrong value) on the cycle after the strobe, so the bench unlocks after every program step and after reset pulses to expose the code. A wrong block decode shows only as a wrong verdict for that block number, which is why every block is swept under each protection and each boot orientation.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
  typedef enum logic {
    BOOT_BOTTOM = 1'b0,
    BOOT_TOP    = 1'b1
  } boot_e;
endpackage

// File: rtl/wrprot_blkmap.sv
module wrprot_blkmap
  import wrprot_pkg::*;
#(
  parameter int    NUM_BLOCKS = 39,
  parameter int    NUM_PARAM  = 8,
  parameter int    LOCK_PARAM = 2,
  parameter int    SOFT_MAIN  = 24,
  parameter boot_e BOOT       = BOOT_BOTTOM,
  parameter int    BLK_W      = 6
) (
  input  logic [BLK_W-1:0] blk,
  output logic             in_range,
  output logic             sw_cov,
  output logic             wp_cov
);
  localparam int NUM_MAIN = NUM_BLOCKS - NUM_PARAM;

  logic [31:0] b32;
  logic        is_main;
  logic        lock_par;
  logic        soft_main;

  assign b32      = 32'(blk);
  assign in_range = b32 < 32'(NUM_BLOCKS);

  generate
    if (BOOT == BOOT_BOTTOM) begin : g_bottom
      // parameter blocks low, main blocks above them
      assign is_main   = in_range && (b32 >= 32'(NUM_PARAM));
      assign lock_par  = b32 < 32'(LOCK_PARAM);
      assign soft_main = in_range && (b32 >= 32'(NUM_BLOCKS - SOFT_MAIN));
    end else begin : g_top
      // main blocks low, parameter blocks at the top
      assign is_main   = b32 < 32'(NUM_MAIN);
      assign lock_par  = in_range && (b32 >= 32'(NUM_BLOCKS - LOCK_PARAM));
      assign soft_main = b32 < 32'(SOFT_MAIN);
    end
  endgenerate

  assign wp_cov = is_main || lock_par;
  assign sw_cov = lock_par || soft_main;

  always_comb begin
    // an out-of-range block must not decode as a main or soft-locked block
    a_range_r11: assert (in_range || !(is_main || soft_main));
  end
endmodule

// File: rtl/wrprot_code.sv
module wrprot_code #(
  parameter int CODE_W       = 64,
  parameter bit SOFT_LOCK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              active,
  input  logic              unl_valid,
  input  logic [CODE_W-1:0] unl_code,
  input  logic              prg_valid,
  input  logic [CODE_W-1:0] prg_data,
  output logic              locked
);
  generate
    if (SOFT_LOCK_EN) begin : g_sw
      logic [CODE_W-1:0] code_q;
      logic              lock_q;
      logic              match;
      logic              frozen;
      logic              prg_ok;

      assign match  = unl_valid && active && (unl_code == code_q);
      assign frozen = ~|code_q;
      assign prg_ok = prg_valid && active && !lock_q && !frozen;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= '1;
          lock_q <= 1'b1;
        end else begin
          if (!rp_n)      lock_q <= 1'b1;
          else if (match) lock_q <= 1'b0;
          if (prg_ok)     code_q <= code_q & prg_data;
        end
      end

      assign locked = lock_q;

      p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((code_q & ~$past(code_q)) == '0));
      p_locked_keeps_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(code_q));
      p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(code_q));
      p_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> lock_q);
    end else begin : g_nosw
      assign locked = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wrprot_gate.sv
module wrprot_gate
  import wrprot_pkg::*;
#(
  parameter int    NUM_BLOCKS   = 39,
  parameter int    NUM_PARAM    = 8,
  parameter int    LOCK_PARAM   = 2,
  parameter int    SOFT_MAIN    = 24,
  parameter int    CODE_W       = 64,
  parameter int    PWRUP_CYC    = 4,
  parameter boot_e BOOT         = BOOT_BOTTOM,
  parameter bit    SOFT_LOCK_EN = 1'b1,
  parameter int    BLK_W        = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              wp_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              rsp_valid,
  output logic              rsp_grant,
  input  logic              unl_valid,
  input  logic [CODE_W-1:0] unl_code,
  input  logic              prg_valid,
  input  logic [CODE_W-1:0] prg_data,
  input  logic              err_clr,
  output logic              prot_err,
  output logic              soft_locked
);
  localparam int PU_W = $clog2(PWRUP_CYC + 2);

  logic [PU_W-1:0] pu_cnt;
  logic            pu_busy;
  logic            active;
  logic            in_range;
  logic            sw_cov;
  logic            wp_cov;
  logic            locked;
  logic            grant;

  // power-up settle window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pu_cnt <= PU_W'(PWRUP_CYC);
    else if (pu_busy) pu_cnt <= pu_cnt - 1'b1;
  end
  assign pu_busy = pu_cnt != '0;
  assign active  = rp_n && !pu_busy;

  wrprot_blkmap #(
    .NUM_BLOCKS(NUM_BLOCKS), .NUM_PARAM(NUM_PARAM), .LOCK_PARAM(LOCK_PARAM),
    .SOFT_MAIN(SOFT_MAIN), .BOOT(BOOT), .BLK_W(BLK_W)
  ) u_map (
    .blk(req_blk), .in_range(in_range), .sw_cov(sw_cov), .wp_cov(wp_cov)
  );

  wrprot_code #(.CODE_W(CODE_W), .SOFT_LOCK_EN(SOFT_LOCK_EN)) u_code (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .active(active),
    .unl_valid(unl_valid), .unl_code(unl_code),
    .prg_valid(prg_valid), .prg_data(prg_data), .locked(locked)
  );

  assign grant = in_range && active
              && !(sw_cov && locked)
              && !(wp_cov && !wp_n);

  assign req_ready   = 1'b1;
  assign soft_locked = locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      prot_err  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && grant;
      if (req_valid && !grant) prot_err <= 1'b1;
      else if (err_clr)        prot_err <= 1'b0;
    end
  end

  p_pwrup_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_busy && req_valid) |=> !rsp_grant);
  p_rp_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_n && req_valid) |=> !rsp_grant);
  p_lock_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sw_cov && locked) |=> !rsp_grant);
  p_wp_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wp_cov && !wp_n) |=> !rsp_grant);
  p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_err && !err_clr) |=> prot_err);
endmodule

// File: tb/wrprot_gate_bench.sv
module wrprot_gate_bench;
  import wrprot_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rp_n = 1'b1;
  logic        wp_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_blk = '0;
  logic        unl_valid = 1'b0;
  logic [63:0] unl_code = '0;
  logic        prg_valid = 1'b0;
  logic [63:0] prg_data = '1;
  logic        err_clr = 1'b0;

  logic [2:0] d_ready, d_rv, d_rg, d_err, d_lock;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string tag = "R1";
  bit    started = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // instance 0: bottom boot, instance 1: top boot, instance 2: no software lock
  wrprot_gate u_wrprot_gate (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
    .req_valid(req_valid), .req_ready(d_ready[0]), .req_blk(req_blk),
    .rsp_valid(d_rv[0]), .rsp_grant(d_rg[0]),
    .unl_valid(unl_valid), .unl_code(unl_code),
    .prg_valid(prg_valid), .prg_data(prg_data),
    .err_clr(err_clr), .prot_err(d_err[0]), .soft_locked(d_lock[0]));

  wrprot_gate #(.BOOT(BOOT_TOP)) u_top_boot (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
    .req_valid(req_valid), .req_ready(d_ready[1]), .req_blk(req_blk),
    .rsp_valid(d_rv[1]), .rsp_grant(d_rg[1]),
    .unl_valid(unl_valid), .unl_code(unl_code),
    .prg_valid(prg_valid), .prg_data(prg_data),
    .err_clr(err_clr), .prot_err(d_err[1]), .soft_locked(d_lock[1]));

  wrprot_gate #(.SOFT_LOCK_EN(1'b0)) u_no_soft (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n),
    .req_valid(req_valid), .req_ready(d_ready[2]), .req_blk(req_blk),
    .rsp_valid(d_rv[2]), .rsp_grant(d_rg[2]),
    .unl_valid(unl_valid), .unl_code(unl_code),
    .prg_valid(prg_valid), .prg_data(prg_data),
    .err_clr(err_clr), .prot_err(d_err[2]), .soft_locked(d_lock[2]));

  // ---------------- reference model ----------------
  logic [63:0] m_code;
  bit          m_lock;
  int          m_pu;
  bit          m_rv[3], m_rg[3], m_err[3];

  function automatic bit soft_cov(int i, int b);
    if (i == 0) return (b <= 1) || (b >= 15 && b <= 38);   // R5 bottom
    if (i == 1) return (b <= 23) || b == 37 || b == 38;    // R5 top
    return 1'b0;                                           // R10
  endfunction

  function automatic bit wp_cov(int i, int b);
    if (i == 1) return (b <= 30) || b == 37 || b == 38;    // R6 top
    return (b <= 1) || (b >= 8 && b <= 38);                // R6 bottom
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_code = '1; m_lock = 1'b1; m_pu = 4;
      for (int i = 0; i < 3; i++) begin m_rv[i] = 0; m_rg[i] = 0; m_err[i] = 0; end
    end else begin
      bit act;
      act = rp_n && (m_pu == 0);
      for (int i = 0; i < 3; i++) begin
        bit g, lk;
        lk = (i == 2) ? 1'b0 : m_lock;
        g  = req_valid && (int'(req_blk) < 39) && act
             && !(soft_cov(i, int'(req_blk)) && lk)
             && !(wp_cov(i, int'(req_blk)) && !wp_n);
        m_rv[i] = req_valid;
        m_rg[i] = g;
        if (req_valid && !g) m_err[i] = 1;
        else if (err_clr)    m_err[i] = 0;
      end
      if (act && prg_valid && !m_lock && m_code != 0) m_code = m_code & prg_data;
      if (!rp_n) m_lock = 1;
      else if (act && unl_valid && unl_code == m_code) m_lock = 0;
      if (m_pu > 0) m_pu--;
    end
  end

  task automatic chk(string t, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", t, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < 3; i++) begin
        string t;
        t = (i == 2) ? {"R10/", tag} : tag;
        $sformat(t, "%s dut%0d", t, i);
        chk(t, "req_ready R11", d_ready[i], 1'b1);
        chk(t, "rsp_valid", d_rv[i], m_rv[i]);
        chk(t, "rsp_grant", d_rg[i], m_rg[i]);
        chk(t, "prot_err", d_err[i], m_err[i]);
        chk(t, "soft_locked", d_lock[i], (i == 2) ? 1'b0 : m_lock);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R11 watchdog: actual cycle %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic req(int b);
    @(negedge clk); req_valid = 1'b1; req_blk = 6'(b);
    @(negedge clk); req_valid = 1'b0;
  endtask
  task automatic unlock(logic [63:0] c);
    @(negedge clk); unl_valid = 1'b1; unl_code = c;
    @(negedge clk); unl_valid = 1'b0;
  endtask
  task automatic prog(logic [63:0] d);
    @(negedge clk); prg_valid = 1'b1; prg_data = d;
    @(negedge clk); prg_valid = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic sweep(int lo, int hi);
    for (int b = lo; b <= hi; b++) req(b);
  endtask
  task automatic rp_pulse();
    @(negedge clk); rp_n = 1'b0;
    @(negedge clk); rp_n = 1'b1;
  endtask

  localparam logic [63:0] MASK_A = 64'hFFFF_0000_FFFF_FF0F;
  localparam logic [63:0] MASK_B = 64'h0F0F_FFFF_F0F0_FFFF;
  localparam logic [63:0] CODE_AB = MASK_A & MASK_B;

  initial begin
    idle(3);
    tag = "R1";
    @(negedge clk); rst_n = 1'b1;
    tag = "R9";                 // power-up window: deny all, ignore unlock
    req(5);
    unlock('1);
    idle(4);
    tag = "R5";                 // locked, pins high
    sweep(0, 38);
    tag = "R11";
    sweep(39, 40);
    tag = "R6";                 // write-protect low
    wp_n = 1'b0;
    sweep(0, 38);
    wp_n = 1'b1;
    tag = "R2";                 // wrong code then right code
    unlock(64'h0000_0000_0000_1234);
    req(20);
    unlock('1);
    sweep(0, 38);
    tag = "R3";                 // clear-only programming while unlocked
    prog(MASK_A);
    prog(MASK_B);
    unlock(64'h1);              // wrong value: stays unlocked
    req(30);
    tag = "R7";                 // reset pin: deny, ignore, relock
    @(negedge clk); rp_n = 1'b0;
    req(3);
    unlock(CODE_AB);
    prog(64'h0);
    @(negedge clk); rp_n = 1'b1;
    tag = "R8";
    req(20);
    req(5);
    tag = "R3";                 // program while locked is ignored
    prog(64'h0);
    unlock('1);
    unlock(CODE_AB);
    req(20);
    tag = "R4";                 // freeze at all zeros
    prog(64'h0);
    prog('1);
    rp_pulse();
    unlock('1);
    unlock(64'h0);
    prog(64'hFFFF_FFFF_0000_0000);
    rp_pulse();
    unlock(64'h0);
    req(24);
    tag = "R12";                // sticky error and clear priority
    req(40);
    idle(3);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    req(5);
    @(negedge clk); err_clr = 1'b1; req_valid = 1'b1; req_blk = 6'd39;
    @(negedge clk); err_clr = 1'b0; req_valid = 1'b0;
    idle(2);
    tag = "R1";                 // full reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(6);
    unlock(CODE_AB);
    unlock('1);
    req(0);
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule